// File: doc/BRIEF.md
# Indexed Load/Store Address Sequencer

This block executes one register-indirect memory transfer of a small 8-bit CPU datapath per request. A decoder upstream hands it an already-decoded request: which base register to use, an 8-bit displacement, byte or word size, load or store, a register code, an alternate-bank flag and an immediate byte. The current register values come in as plain inputs. The block checks that the combination is legal and forms the effective address. It then runs one or two byte cycles on a memory bus with a ready handshake. At the end it reports a single register writeback and a done pulse, or an error pulse if the request was illegal.

Every request input, including the register values, is captured when the request is accepted. The register file may therefore change while a transfer is in flight, and the transfer still uses the values it captured. This matters most for a word load into HL that uses HL as its base: both byte addresses come from the HL value held before the load.

Top module: `idxmem_seq`

## Requirements
- R1: Base codes are 0=IX, 1=IY, 2=SP, 3=HL, 4=BC, 5=DE. The effective address is the base plus the displacement, modulo 65536. The displacement is zero-extended (0..255) for SP and sign-extended (-128..+127) for IX, IY and HL.
- R2: BC and DE are legal bases only for byte transfers with register code 6 (accumulator). For those transfers the displacement is ignored and the address is the pair's value. A word transfer or any other register code on these bases is illegal.
- R3: A word load reads the effective address first and the effective address plus one (wrapping to 0x0000) second. It writes back {second byte, first byte} with register code 4 (HL), and wbAlt carries the request's bank flag.
- R4: A word store always takes its data from HL. It writes the low byte of HL to the effective address first, then the high byte to the effective address plus one.
- R5: The base value and the store data are captured at acceptance. Later changes to the register inputs do not affect the addresses or data of a transfer in flight.
- R6: A byte load writes back {0x00, byte} with the request's register code (0=B, 1=C, 2=D, 3=E, 4=H, 5=L, 6=A) and its bank flag. Register code 7 on a byte load is illegal.
- R7: A byte store writes the selected primary register (codes 0..6 as in R6) or, for code 7, the immediate byte.
- R8: Any store with the alternate-bank flag set is illegal, including a store through HL. A byte transfer based on SP is also illegal.
- R9: While memValid is high and memReady is low, memAddr, memWe and memWdata hold their values. Each byte is transferred in a cycle where both are high.
- R10: A load raises wbValid for exactly one cycle, together with done, in the cycle after its last byte is accepted. A store raises done in that cycle with no writeback.
- R11: An illegal request raises err in the cycle after acceptance. It performs no memory cycle, no writeback and no done.
- R12: Requests are accepted only while the block is idle. A request presented during a transfer is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqBase | input | 3 | Base register code |
| reqDisp | input | 8 | Displacement byte |
| reqWord | input | 1 | 1 = word transfer |
| reqStore | input | 1 | 1 = store, 0 = load |
| reqReg | input | 3 | Register code, 7 = immediate |
| reqAlt | input | 1 | Alternate-bank flag |
| reqImm | input | 8 | Immediate data byte |
| regIx | input | 16 | Current IX |
| regIy | input | 16 | Current IY |
| regSp | input | 16 | Current SP |
| regHl | input | 16 | Current HL |
| regBc | input | 16 | Current BC |
| regDe | input | 16 | Current DE |
| regA | input | 8 | Current accumulator |
| memValid | output | 1 | Bus cycle active |
| memAddr | output | 16 | Byte address |
| memWe | output | 1 | Write strobe |
| memWdata | output | 8 | Write data |
| memRdata | input | 8 | Read data |
| memReady | input | 1 | Memory accepts the cycle |
| wbValid | output | 1 | Register writeback strobe |
| wbWord | output | 1 | Writeback is 16 bits |
| wbReg | output | 3 | Writeback register code |
| wbAlt | output | 1 | Writeback goes to alternate bank |
| wbData | output | 16 | Writeback value |
| done | output | 1 | Legal transfer finished |
| err | output | 1 | Illegal request rejected |

## Verification
A wrong captured base or a wrong extension of the displacement shows up on memAddr in the first bus cycle. A broken plus-one or wrap path shows up in the second cycle of a word transfer. A sequencer that loses track of the byte count surfaces within one cycle of the last acceptance: done comes early or late, a bus cycle is extra or missing, or a partial word is written back. Legality mistakes appear in the cycle after acceptance, as an err that should not be there or a bus cycle where err was due. The reference model checks the bus on every cycle where memValid is high, and checks done, err and wbValid whenever any of them is asserted.

// File: rtl/idxmem_pkg.sv
package idxmem_pkg;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CODE_W = 3;

  localparam logic [CODE_W-1:0] BASE_IX = 3'd0;
  localparam logic [CODE_W-1:0] BASE_IY = 3'd1;
  localparam logic [CODE_W-1:0] BASE_SP = 3'd2;
  localparam logic [CODE_W-1:0] BASE_HL = 3'd3;
  localparam logic [CODE_W-1:0] BASE_BC = 3'd4;
  localparam logic [CODE_W-1:0] BASE_DE = 3'd5;

  localparam logic [CODE_W-1:0] REG_H   = 3'd4;
  localparam logic [CODE_W-1:0] REG_A   = 3'd6;
  localparam logic [CODE_W-1:0] REG_IMM = 3'd7;

  typedef struct packed {
    logic latchReq;  // capture request at acceptance
    logic capLo;     // store first byte read
    logic capHi;     // store second byte read
    logic useHi;     // drive second byte address/data
  } ctrl_strobe_t;
endpackage

// File: rtl/idxmem_ctrl.sv
module idxmem_ctrl
  import idxmem_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         reqLegal,
  input  logic         wordQ,
  input  logic         storeQ,
  input  logic         memReady,
  output ctrl_strobe_t strobe,
  output logic         memValid,
  output logic         wbValid,
  output logic         done,
  output logic         err
);
  typedef enum logic [2:0] {S_IDLE, S_LO, S_HI, S_FIN, S_ERR} state_t;
  state_t stateQ, stateD;

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= S_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD   = stateQ;
    strobe   = '0;
    memValid = 1'b0;
    wbValid  = 1'b0;
    done     = 1'b0;
    err      = 1'b0;
    unique case (stateQ)
      S_IDLE: if (reqValid) begin
        if (reqLegal) begin
          strobe.latchReq = 1'b1;
          stateD = S_LO;
        end else begin
          stateD = S_ERR;
        end
      end
      S_LO: begin
        memValid = 1'b1;
        if (memReady) begin
          strobe.capLo = 1'b1;
          stateD = wordQ ? S_HI : S_FIN;
        end
      end
      S_HI: begin
        memValid     = 1'b1;
        strobe.useHi = 1'b1;
        if (memReady) begin
          strobe.capHi = 1'b1;
          stateD = S_FIN;
        end
      end
      S_FIN: begin
        done    = 1'b1;
        wbValid = !storeQ;
        stateD  = S_IDLE;
      end
      S_ERR: begin
        err    = 1'b1;
        stateD = S_IDLE;
      end
      default: stateD = S_IDLE;
    endcase
  end
endmodule

// File: rtl/idxmem_dp.sv
module idxmem_dp
  import idxmem_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned BW = BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_strobe_t      strobe,
  input  logic [CODE_W-1:0] reqBase,
  input  logic [BW-1:0]     reqDisp,
  input  logic              reqWord,
  input  logic              reqStore,
  input  logic [CODE_W-1:0] reqReg,
  input  logic              reqAlt,
  input  logic [BW-1:0]     reqImm,
  input  logic [AW-1:0]     regIx,
  input  logic [AW-1:0]     regIy,
  input  logic [AW-1:0]     regSp,
  input  logic [AW-1:0]     regHl,
  input  logic [AW-1:0]     regBc,
  input  logic [AW-1:0]     regDe,
  input  logic [BW-1:0]     regA,
  input  logic [BW-1:0]     memRdata,
  output logic              reqLegal,
  output logic              wordQ,
  output logic              storeQ,
  output logic [AW-1:0]     memAddr,
  output logic [BW-1:0]     memWdata,
  output logic [CODE_W-1:0] wbReg,
  output logic              wbAlt,
  output logic [2*BW-1:0]   wbData
);
  localparam int unsigned PAD_W = AW - BW;

  logic              isPair;
  logic [AW-1:0]     baseVal, dispExt, eaNext;
  logic [BW-1:0]     byteSrc;
  logic [2*BW-1:0]   dataNext;
  logic [AW-1:0]     eaQ;
  logic [2*BW-1:0]   dataQ;
  logic [CODE_W-1:0] regQ;
  logic              altQ;
  logic [BW-1:0]     rdLoQ, rdHiQ;

  assign isPair = (reqBase == BASE_BC) || (reqBase == BASE_DE);

  always_comb begin
    reqLegal = 1'b1;
    if (reqBase > BASE_DE)                                   reqLegal = 1'b0;
    if (isPair && (reqWord || reqReg != REG_A))              reqLegal = 1'b0;
    if (reqStore && reqAlt)                                  reqLegal = 1'b0;
    if (!reqWord && reqBase == BASE_SP)                      reqLegal = 1'b0;
    if (!reqWord && !reqStore && reqReg == REG_IMM)          reqLegal = 1'b0;
  end

  always_comb begin
    unique case (reqBase)
      BASE_IX: baseVal = regIx;
      BASE_IY: baseVal = regIy;
      BASE_SP: baseVal = regSp;
      BASE_HL: baseVal = regHl;
      BASE_BC: baseVal = regBc;
      BASE_DE: baseVal = regDe;
      default: baseVal = '0;
    endcase
    if (isPair)                 dispExt = '0;
    else if (reqBase == BASE_SP) dispExt = {{PAD_W{1'b0}}, reqDisp};
    else                        dispExt = {{PAD_W{reqDisp[BW-1]}}, reqDisp};
    eaNext = baseVal + dispExt;
  end

  always_comb begin
    unique case (reqReg)
      3'd0:    byteSrc = regBc[2*BW-1:BW];
      3'd1:    byteSrc = regBc[BW-1:0];
      3'd2:    byteSrc = regDe[2*BW-1:BW];
      3'd3:    byteSrc = regDe[BW-1:0];
      3'd4:    byteSrc = regHl[2*BW-1:BW];
      3'd5:    byteSrc = regHl[BW-1:0];
      3'd6:    byteSrc = regA;
      default: byteSrc = reqImm;
    endcase
    dataNext = reqWord ? regHl[2*BW-1:0] : {{BW{1'b0}}, byteSrc};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      eaQ <= '0; dataQ <= '0; regQ <= '0; altQ <= 1'b0;
      wordQ <= 1'b0; storeQ <= 1'b0; rdLoQ <= '0; rdHiQ <= '0;
    end else begin
      if (strobe.latchReq) begin
        eaQ    <= eaNext;
        dataQ  <= dataNext;
        regQ   <= reqWord ? REG_H : reqReg;
        altQ   <= reqAlt;
        wordQ  <= reqWord;
        storeQ <= reqStore;
        rdHiQ  <= '0;
      end
      if (strobe.capLo) rdLoQ <= memRdata;
      if (strobe.capHi) rdHiQ <= memRdata;
    end
  end

  assign memAddr  = strobe.useHi ? eaQ + AW'(1) : eaQ;
  assign memWdata = strobe.useHi ? dataQ[2*BW-1:BW] : dataQ[BW-1:0];
  assign wbReg    = regQ;
  assign wbAlt    = altQ;
  assign wbData   = {rdHiQ, rdLoQ};
endmodule

// File: rtl/idxmem_seq.sv
module idxmem_seq
  import idxmem_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic [2:0]  reqBase,
  input  logic [7:0]  reqDisp,
  input  logic        reqWord,
  input  logic        reqStore,
  input  logic [2:0]  reqReg,
  input  logic        reqAlt,
  input  logic [7:0]  reqImm,
  input  logic [15:0] regIx,
  input  logic [15:0] regIy,
  input  logic [15:0] regSp,
  input  logic [15:0] regHl,
  input  logic [15:0] regBc,
  input  logic [15:0] regDe,
  input  logic [7:0]  regA,
  output logic        memValid,
  output logic [15:0] memAddr,
  output logic        memWe,
  output logic [7:0]  memWdata,
  input  logic [7:0]  memRdata,
  input  logic        memReady,
  output logic        wbValid,
  output logic        wbWord,
  output logic [2:0]  wbReg,
  output logic        wbAlt,
  output logic [15:0] wbData,
  output logic        done,
  output logic        err
);
  ctrl_strobe_t strobe;
  logic reqLegal, wordQ, storeQ;

  idxmem_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqLegal(reqLegal),
    .wordQ(wordQ), .storeQ(storeQ), .memReady(memReady), .strobe(strobe),
    .memValid(memValid), .wbValid(wbValid), .done(done), .err(err)
  );

  idxmem_dp #(.AW(ADDR_W), .BW(BYTE_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .reqBase(reqBase), .reqDisp(reqDisp), .reqWord(reqWord), .reqStore(reqStore),
    .reqReg(reqReg), .reqAlt(reqAlt), .reqImm(reqImm),
    .regIx(regIx), .regIy(regIy), .regSp(regSp), .regHl(regHl),
    .regBc(regBc), .regDe(regDe), .regA(regA), .memRdata(memRdata),
    .reqLegal(reqLegal), .wordQ(wordQ), .storeQ(storeQ),
    .memAddr(memAddr), .memWdata(memWdata), .wbReg(wbReg), .wbAlt(wbAlt),
    .wbData(wbData)
  );

  assign memWe  = memValid && storeQ;
  assign wbWord = wordQ;
endmodule

// File: rtl/idxmem_seq_chk.sv
module idxmem_seq_chk (
  input logic        clk,
  input logic        rstN,
  input logic        memValid,
  input logic        memReady,
  input logic [15:0] memAddr,
  input logic        memWe,
  input logic [7:0]  memWdata,
  input logic        wbValid,
  input logic        done,
  input logic        err
);
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    memValid && !memReady |=> memValid && $stable(memAddr) && $stable(memWe) && $stable(memWdata));

  assert_err_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    err |-> !memValid && !wbValid && !done);

  assert_err_from_idle_R11: assert property (@(posedge clk) disable iff (!rstN)
    err |-> $past(!memValid));

  assert_wb_with_done_R10: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> done && !memValid);

  assert_done_after_accept_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(memValid && memReady));

  assert_single_wb_R10: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |=> !wbValid);
endmodule

bind idxmem_seq idxmem_seq_chk chk_i (.*);

// File: tb/idxmem_seq_tb.sv
module idxmem_seq_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWord = 1'b0, reqStore = 1'b0, reqAlt = 1'b0;
  logic [2:0] reqBase = '0, reqReg = '0;
  logic [7:0] reqDisp = '0, reqImm = '0, regA = 8'h3C;
  logic [15:0] regIx = 16'h1000, regIy = 16'h2080, regSp = 16'hFF80;
  logic [15:0] regHl = 16'h4321, regBc = 16'h5A6B, regDe = 16'h7C8D;
  logic memValid, memWe, memReady = 1'b1, wbValid, wbWord, wbAlt, done, err;
  logic [15:0] memAddr, wbData;
  logic [7:0] memWdata, memRdata;
  logic [2:0] wbReg;

  function automatic logic [7:0] memF(logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction
  assign memRdata = memValid ? memF(memAddr) : 8'h00;

  idxmem_seq dut_i (.*);

  typedef struct { logic [15:0] addr; logic we; logic [7:0] data; } acc_t;
  acc_t expQ[$];
  int nChecks = 0, nFail = 0, waitMod = 1, rdyCnt = 0, expKind = 0;
  logic [15:0] expWb; logic [2:0] expReg; logic expAlt, expWord;
  bit started = 0, endSeen = 0, doneDue = 0, finished = 0;
  string curTag = "";

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s (%s): actual %0h expected %0h", req, what, curTag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    rdyCnt++;
    memReady = (rdyCnt % waitMod) == 0;
  end

  // reference model compared every clock
  always @(negedge clk) if (rstN && started) begin
    if (doneDue) begin
      check(done === 1'b1, "R10", "done after last byte", 32'(done), 1);
      doneDue = 0;
    end
    if (memValid) begin
      if (expQ.size() == 0) begin
        check(0, "R11/R12", "unexpected bus cycle", 32'(memAddr), 0);
      end else begin
        check(memAddr === expQ[0].addr, "R1/R3", "address", 32'(memAddr), 32'(expQ[0].addr));
        check(memWe === expQ[0].we, "R9", "write strobe", 32'(memWe), 32'(expQ[0].we));
        if (expQ[0].we)
          check(memWdata === expQ[0].data, "R4/R7", "write data", 32'(memWdata), 32'(expQ[0].data));
        if (memReady) begin
          void'(expQ.pop_front());
          if (expQ.size() == 0) doneDue = 1;
        end
      end
    end
    if (wbValid) begin
      check(expKind == 1, "R10", "writeback on non-load", 32'(wbValid), 0);
      check(wbData === expWb, "R3/R6", "writeback data", 32'(wbData), 32'(expWb));
      check(wbReg === expReg, "R6", "writeback reg", 32'(wbReg), 32'(expReg));
      check(wbAlt === expAlt, "R6", "writeback bank", 32'(wbAlt), 32'(expAlt));
      check(wbWord === expWord, "R3", "writeback size", 32'(wbWord), 32'(expWord));
    end
    if (done) begin
      check(expKind != 2, "R11", "done on illegal", 1, 0);
      check(expQ.size() == 0, "R10", "done before all bytes", 32'(expQ.size()), 0);
      check(wbValid === (expKind == 1), "R10", "writeback with done", 32'(wbValid), 32'(expKind == 1));
      endSeen = 1;
    end
    if (err) begin
      check(expKind == 2, "R11", "err on legal", 1, 0);
      endSeen = 1;
    end
  end

  function automatic logic [15:0] calcEa(logic [2:0] b, logic [7:0] d);
    case (b)
      3'd0: return regIx + {{8{d[7]}}, d};
      3'd1: return regIy + {{8{d[7]}}, d};
      3'd2: return regSp + {8'h00, d};
      3'd3: return regHl + {{8{d[7]}}, d};
      3'd4: return regBc;
      default: return regDe;
    endcase
  endfunction

  function automatic logic [7:0] srcByte(logic [2:0] r, logic [7:0] imm);
    case (r)
      3'd0: return regBc[15:8];  3'd1: return regBc[7:0];
      3'd2: return regDe[15:8];  3'd3: return regDe[7:0];
      3'd4: return regHl[15:8];  3'd5: return regHl[7:0];
      3'd6: return regA;
      default: return imm;
    endcase
  endfunction

  task automatic runReq(string tag, logic [2:0] b, logic [7:0] d, logic w, logic s,
                        logic [2:0] r, logic alt, logic [7:0] imm, bit illegal,
                        int wm, bit moveHl, bit poke);
    logic [15:0] ea, savedHl;
    acc_t a;
    curTag = tag; waitMod = wm; endSeen = 0; savedHl = regHl;
    ea = calcEa(b, d);
    expKind = illegal ? 2 : (s ? 0 : 1);
    expWord = w; expAlt = alt; expReg = w ? 3'd4 : r;
    if (!illegal) begin
      a.addr = ea; a.we = s; a.data = w ? regHl[7:0] : srcByte(r, imm);
      expQ.push_back(a);
      if (w) begin
        a.addr = ea + 16'd1; a.data = regHl[15:8];
        expQ.push_back(a);
      end
      expWb = w ? {memF(ea + 16'd1), memF(ea)} : {8'h00, memF(ea)};
    end
    reqBase = b; reqDisp = d; reqWord = w; reqStore = s; reqReg = r; reqAlt = alt; reqImm = imm;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    if (illegal) check(err === 1'b1, "R11", "err one cycle after request", 32'(err), 1);
    if (moveHl) begin regHl = 16'hBEEF; regIx = 16'h0BAD; end
    if (poke) begin
      reqBase = 3'd7; reqValid = 1'b1;
      @(negedge clk);
      reqValid = 1'b0;
    end
    for (int i = 0; i < 60 && !endSeen; i++) @(negedge clk);
    check(endSeen, "R10/R11", "request completed", 32'(endSeen), 1);
    @(negedge clk);
    check(expQ.size() == 0, "R3/R4", "all bytes transferred", 32'(expQ.size()), 0);
    expQ.delete();
    regHl = savedHl; regIx = 16'h1000;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  endtask

  initial begin
    #200000;
    nChecks++; nFail++;
    $display("FAIL watchdog: run did not complete");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(memValid === 1'b0 && done === 1'b0 && err === 1'b0 && wbValid === 1'b0,
          "R10/R11", "reset outputs idle", {memValid, done, err, wbValid}, 0);
    rstN = 1'b1;
    @(negedge clk);
    started = 1;
    runReq("R1 R6 byte load IX +5 into B",        3'd0, 8'h05, 0, 0, 3'd0, 0, 8'h00, 0, 1, 0, 0);
    runReq("R1 R6 byte load IY -128 into A'",     3'd1, 8'h80, 0, 0, 3'd6, 1, 8'h00, 0, 2, 0, 0);
    runReq("R1 R3 word load SP +255 zero-ext",    3'd2, 8'hFF, 1, 0, 3'd0, 0, 8'h00, 0, 1, 0, 0);
    regSp = 16'hFFFF;
    runReq("R3 word load SP wraps high byte",     3'd2, 8'h00, 1, 0, 3'd0, 1, 8'h00, 0, 3, 0, 0);
    runReq("R5 word load HL-based HL' moved",     3'd3, 8'hFE, 1, 0, 3'd0, 1, 8'h00, 0, 2, 1, 0);
    runReq("R4 R9 word store IX with waits",      3'd0, 8'h10, 1, 1, 3'd0, 0, 8'h00, 0, 3, 1, 0);
    runReq("R7 byte store HL from H",             3'd3, 8'h00, 0, 1, 3'd4, 0, 8'h00, 0, 1, 0, 0);
    runReq("R7 byte store IX immediate",          3'd0, 8'hF0, 0, 1, 3'd7, 0, 8'h99, 0, 2, 0, 0);
    runReq("R7 byte store IY from A",             3'd1, 8'h7F, 0, 1, 3'd6, 0, 8'h00, 0, 2, 0, 0);
    runReq("R2 BC load A' ignores disp",          3'd4, 8'h33, 0, 0, 3'd6, 1, 8'h00, 0, 1, 0, 0);
    runReq("R2 DE store A",                       3'd5, 8'h44, 0, 1, 3'd6, 0, 8'h00, 0, 2, 0, 0);
    runReq("R8 R11 HL byte store alt illegal",    3'd3, 8'h00, 0, 1, 3'd2, 1, 8'h00, 1, 1, 0, 0);
    runReq("R2 BC word load illegal",             3'd4, 8'h00, 1, 0, 3'd6, 0, 8'h00, 1, 1, 0, 0);
    runReq("R2 DE with B illegal",                3'd5, 8'h00, 0, 0, 3'd0, 0, 8'h00, 1, 1, 0, 0);
    runReq("R8 SP byte load illegal",             3'd2, 8'h01, 0, 0, 3'd0, 0, 8'h00, 1, 1, 0, 0);
    runReq("R6 byte load code 7 illegal",         3'd0, 8'h01, 0, 0, 3'd7, 0, 8'h00, 1, 1, 0, 0);
    runReq("R8 word store alt illegal",           3'd1, 8'h01, 1, 1, 3'd0, 1, 8'h00, 1, 1, 0, 0);
    runReq("R12 request while busy ignored",      3'd1, 8'h02, 1, 0, 3'd0, 0, 8'h00, 0, 3, 0, 1);
    runReq("R12 idle again after busy poke",      3'd0, 8'h03, 0, 0, 3'd5, 0, 8'h00, 0, 1, 0, 0);
    repeat (4) @(negedge clk);
    finish();
  end
endmodule